// File: doc/BRIEF.md
# NAND Reset and Identification Bring-Up Sequencer

This block is a host-side controller that prepares a raw 8-bit NAND device after power-up. A single start pulse makes it send the device reset command. It then watches the ready/busy line until the device has gone busy and become ready again. Next it sends the identification command and its one address byte, and reads back four identification bytes. The sequencer drives the device control strobes and the outgoing byte bus directly. Parameters set every pulse width and wait time in clock cycles.

When the sequence ends, the block gives a one-cycle completion pulse and an error flag. The error flag is raised in two cases: the first identification byte is not the expected manufacturer code, or the ready/busy wait ran past a cycle limit. The four captured bytes stay on the output until the next accepted start. Integration logic uses the completion pulse, the flag and the bytes to decide whether the device is usable.

Top module: `nand_bringup`

## Requirements
- R1: A start pulse in the idle state begins the reset command in the next cycle. For that command, CE# is low, CLE is 1 and dout is FFh while WE# is low for WE_LO cycles, and then WE# is high for WE_HI cycles.
- R2: After the reset command, no further command is issued until rb has been sampled low and then sampled high. During this wait, CE# is low and all other strobes are inactive.
- R3: After the wait, the block sends command 90h with CLE=1 and then address byte 00h with ALE=1. Each uses the same WE# low/high timing as R1. CLE, ALE and dout do not change on the cycle where WE# rises, and CLE and ALE are never both 1.
- R4: After the address write, the block waits CMD_RD_CYC cycles with all strobes inactive. It then gives exactly four RE# pulses, each ACC_CYC cycles low and RE_HI cycles high. WE# and RE# are never low together.
- R5: din is sampled on the clock edge that ends each RE# low phase. Read n (0 to 3) goes to id_bytes[8n+7:8n]. id_bytes is cleared to 0 when a start is accepted and otherwise holds its value until the next accepted start.
- R6: When the fourth read completes, error is set to 1 if id_bytes[7:0] is not MAKER_ID (default ECh), and to 0 otherwise.
- R7: If the ready/busy wait lasts BUSY_TMO cycles without completing, error is set and the run ends. In that case no identification command is sent and id_bytes stays 0.
- R8: done is 1 for exactly one cycle at the end of every run, whether normal or timed out. CE# is high in that cycle, and the block is idle in the cycle after it.
- R9: A start pulse received while a run is in progress, including the done cycle, has no effect.
- R10: While reset is asserted, ce_n, we_n and re_n are 1; cle, ale, dout, done, error and id_bytes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the bring-up sequence when idle |
| rb | input | 1 | Device ready/busy, low means busy |
| din | input | 8 | Byte bus from the device |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| dout | output | 8 | Byte bus to the device |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Manufacturer code mismatch or busy timeout |
| id_bytes | output | 32 | Captured identification bytes, first in bits 7:0 |

## Verification
The bench builds the block with WE_LO=2, WE_HI=1, ACC_CYC=2, RE_HI=1, CMD_RD_CYC=3 and BUSY_TMO=40. Because the write and read low phases span several cycles, the checks can tell a hold fault apart from a width fault. The short timeout makes both timeout paths cheap to reach: ready/busy that never drops and ready/busy that never returns. Normal runs remain well inside the limit, and runs with a wrong manufacturer code and with stray start pulses are also exercised.

// File: rtl/nand_bringup.sv
module nand_bringup #(
  parameter int WE_LO = 1,
  parameter int WE_HI = 1,
  parameter int ACC_CYC = 2,
  parameter int RE_HI = 1,
  parameter int CMD_RD_CYC = 3,
  parameter int BUSY_TMO = 100000,
  parameter logic [7:0] MAKER_ID = 8'hEC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        rb,
  input  logic [7:0]  din,
  output logic        cle,
  output logic        ale,
  output logic        ce_n,
  output logic        we_n,
  output logic        re_n,
  output logic [7:0]  dout,
  output logic        done,
  output logic        error,
  output logic [31:0] id_bytes
);
  localparam int M1 = (WE_LO > WE_HI) ? WE_LO : WE_HI;
  localparam int M2 = (ACC_CYC > RE_HI) ? ACC_CYC : RE_HI;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > CMD_RD_CYC) ? M3 : CMD_RD_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam int TW = $clog2(BUSY_TMO + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LO, S_RST_HI, S_WAIT_LO, S_WAIT_HI, S_ID_LO, S_ID_HI,
    S_AD_LO, S_AD_HI, S_GAP, S_RD_LO, S_RD_HI, S_DONE
  } st_t;

  st_t st;
  logic [CW-1:0] cnt, lim;
  logic [TW-1:0] tmo;
  logic [1:0] idx;
  logic last, tmo_end;

  always_comb begin
    case (st)
      S_RST_LO, S_ID_LO, S_AD_LO: lim = CW'(WE_LO - 1);
      S_RST_HI, S_ID_HI, S_AD_HI: lim = CW'(WE_HI - 1);
      S_GAP:                      lim = CW'(CMD_RD_CYC - 1);
      S_RD_LO:                    lim = CW'(ACC_CYC - 1);
      S_RD_HI:                    lim = CW'(RE_HI - 1);
      default:                    lim = '0;
    endcase
  end

  assign last    = (cnt == lim);
  assign tmo_end = (tmo == TW'(BUSY_TMO - 1));

  assign ce_n = (st == S_IDLE) || (st == S_DONE);
  assign we_n = !(st == S_RST_LO || st == S_ID_LO || st == S_AD_LO);
  assign re_n = (st != S_RD_LO);
  assign cle  = (st == S_RST_LO || st == S_RST_HI || st == S_ID_LO || st == S_ID_HI);
  assign ale  = (st == S_AD_LO || st == S_AD_HI);
  assign dout = (st == S_RST_LO || st == S_RST_HI) ? 8'hFF :
                (st == S_ID_LO  || st == S_ID_HI)  ? 8'h90 : 8'h00;
  assign done = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      tmo <= '0;
      idx <= '0;
      error <= 1'b0;
      id_bytes <= '0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (start) begin
            st <= S_RST_LO;
            error <= 1'b0;
            id_bytes <= '0;
            idx <= '0;
          end
        end
        S_RST_LO: if (last) st <= S_RST_HI;
        S_RST_HI: if (last) begin st <= S_WAIT_LO; tmo <= '0; end
        S_WAIT_LO, S_WAIT_HI: begin
          cnt <= '0;
          if (st == S_WAIT_LO && !rb) st <= S_WAIT_HI;
          else if (st == S_WAIT_HI && rb) st <= S_ID_LO;
          else if (tmo_end) begin st <= S_DONE; error <= 1'b1; end
          else tmo <= tmo + 1'b1;
        end
        S_ID_LO: if (last) st <= S_ID_HI;
        S_ID_HI: if (last) st <= S_AD_LO;
        S_AD_LO: if (last) st <= S_AD_HI;
        S_AD_HI: if (last) st <= S_GAP;
        S_GAP:   if (last) st <= S_RD_LO;
        S_RD_LO: if (last) begin
          st <= S_RD_HI;
          id_bytes[8*idx +: 8] <= din;
        end
        S_RD_HI: if (last) begin
          if (idx == 2'd3) begin
            st <= S_DONE;
            error <= (id_bytes[7:0] != MAKER_ID);
          end else begin
            st <= S_RD_LO;
            idx <= idx + 1'b1;
          end
        end
        default: begin st <= S_IDLE; cnt <= '0; end
      endcase
    end
  end
endmodule

// File: rtl/nand_bringup_chk.sv
module nand_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cle,
  input logic        ale,
  input logic        ce_n,
  input logic        we_n,
  input logic        re_n,
  input logic [7:0]  dout,
  input logic        done,
  input logic [31:0] id_bytes
);
  p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n) !(cle && ale));

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !re_n));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

  p_done_ce_r8: assert property (@(posedge clk) disable iff (!rst_n) done |-> ce_n);

  p_we_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n) |=> (we_n ? ($stable(cle) && $stable(ale) && $stable(dout)) : 1'b1));

  p_cmd_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cle |-> (dout == 8'hFF || dout == 8'h90));

  p_id_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !start) |=> $stable(id_bytes));
endmodule

bind nand_bringup nand_bringup_chk u_chk (.*);

// File: tb/test_nand_bringup.sv
`timescale 1ns/1ps
module test_nand_bringup;
  localparam int WE_LO = 2, WE_HI = 1, ACC = 2, RE_HI = 1, GAP = 3, TMO = 40;

  logic clk = 0, rst_n = 0, start = 0, rb = 1;
  logic [7:0] din = 0;
  logic cle, ale, ce_n, we_n, re_n, done, error;
  logic [7:0] dout;
  logic [31:0] id_bytes;

  nand_bringup #(.WE_LO(WE_LO), .WE_HI(WE_HI), .ACC_CYC(ACC), .RE_HI(RE_HI),
                 .CMD_RD_CYC(GAP), .BUSY_TMO(TMO)) i_nand_bringup (
    .clk(clk), .rst_n(rst_n), .start(start), .rb(rb), .din(din), .cle(cle),
    .ale(ale), .ce_n(ce_n), .we_n(we_n), .re_n(re_n), .dout(dout), .done(done),
    .error(error), .id_bytes(id_bytes));

  always #4 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // device model
  int dev_mode = 0;
  logic [7:0] rom [4];
  int k = 0;
  initial forever begin
    @(posedge we_n);
    if (cle && dout == 8'hFF) begin
      if (dev_mode == 0) begin
        repeat (3) @(negedge clk); rb = 0;
        repeat (8) @(negedge clk); rb = 1;
      end else if (dev_mode == 2) begin
        @(negedge clk); rb = 0;
      end
    end
  end
  always @(negedge clk) if (!re_n && k < 4) din <= rom[k];
  always @(posedge re_n) k++;

  // reference model
  logic e_cle, e_ale, e_ce_n, e_we_n, e_re_n, e_done, e_err;
  logic [7:0] e_dout;
  logic [31:0] e_id;

  task automatic set_o(input logic c, a, cen, wen, ren, input logic [7:0] d);
    e_cle = c; e_ale = a; e_ce_n = cen; e_we_n = wen; e_re_n = ren; e_dout = d; e_done = 0;
  endtask
  task automatic step; @(posedge clk); #1; endtask
  task automatic m_wr(input logic [7:0] d, input logic c, a);
    repeat (WE_LO) begin set_o(c, a, 0, 0, 1, d); step(); end
    repeat (WE_HI) begin set_o(c, a, 0, 1, 1, d); step(); end
  endtask
  task automatic m_finish(input logic err);
    set_o(0, 0, 1, 1, 1, 0); e_done = 1; e_err = err; step();
    set_o(0, 0, 1, 1, 1, 0);
  endtask

  initial begin
    set_o(0, 0, 1, 1, 1, 0); e_err = 0; e_id = 0;
    forever begin
      step();
      if (!rst_n) begin set_o(0, 0, 1, 1, 1, 0); e_err = 0; e_id = 0; end
      else if (start) begin
        bit tout, seen;
        int n;
        e_err = 0; e_id = 0;
        m_wr(8'hFF, 1, 0);
        tout = 0; seen = 0; n = 0;
        forever begin
          set_o(0, 0, 0, 1, 1, 0); step();
          if (!seen && !rb) seen = 1;
          else if (seen && rb) break;
          else begin n++; if (n == TMO) begin tout = 1; break; end end
        end
        if (tout) m_finish(1);
        else begin
          m_wr(8'h90, 1, 0);
          m_wr(8'h00, 0, 1);
          repeat (GAP) begin set_o(0, 0, 0, 1, 1, 0); step(); end
          for (int i = 0; i < 4; i++) begin
            repeat (ACC) begin set_o(0, 0, 0, 1, 0, 0); step(); end
            e_id[8*i +: 8] = din;
            repeat (RE_HI) begin set_o(0, 0, 0, 1, 1, 0); step(); end
          end
          m_finish(e_id[7:0] != 8'hEC);
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    chk("R1 cle", cle, e_cle);
    chk("R3 ale", ale, e_ale);
    chk("R2 ce_n", ce_n, e_ce_n);
    chk("R1 we_n", we_n, e_we_n);
    chk("R4 re_n", re_n, e_re_n);
    chk("R3 dout", dout, e_dout);
    chk("R8 done", done, e_done);
    chk("R6 error", error, e_err);
    chk("R5 id_bytes", id_bytes, e_id);
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input int mode, input logic [7:0] b0, b1, b2, b3,
                     input bit stray, input logic exp_err, input string tag);
    int w;
    dev_mode = mode; rom[0] = b0; rom[1] = b1; rom[2] = b2; rom[3] = b3; k = 0;
    rb = 1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    if (stray) begin
      repeat (4) @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      repeat (20) @(negedge clk); start = 1;
      @(negedge clk); start = 0;
    end
    w = 0;
    while (done !== 1'b1 && w < 2000) begin @(negedge clk); w++; end
    if (stray) start = 1;
    @(negedge clk); start = 0;
    chk({tag, " error at end"}, error, exp_err);
    if (mode == 0) chk("R5 captured bytes", id_bytes, {b3, b2, b1, b0});
    else chk("R7 bytes stay zero after timeout", id_bytes, 32'h0);
    repeat (3) @(negedge clk);
    chk("R9 idle after run, no stray restart", ce_n, 1'b1);
    rb = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset ce_n", ce_n, 1'b1);
    chk("R10 reset id", id_bytes, 32'h0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(0, 8'hEC, 8'hF1, 8'h00, 8'h15, 0, 1'b0, "R6");
    run(0, 8'h2C, 8'hA1, 8'h80, 8'h55, 1, 1'b1, "R6");
    run(1, 8'hEC, 8'h00, 8'h00, 8'h00, 0, 1'b1, "R7");
    run(2, 8'hEC, 8'h00, 8'h00, 8'h00, 0, 1'b1, "R7");
    run(0, 8'hEC, 8'hB1, 8'h3C, 8'h95, 1, 1'b0, "R6");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule